// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a signal-processing pipeline. Every clock cycle it can take two signed fractional operands in Q1.(DW-1) format and form their full double-width product. It then adds that product to a wide accumulator, subtracts it, loads it in place of the accumulator, or clears the accumulator. The accumulator carries GUARD extra high-order bits beyond the product width, so long runs of products can be summed without intermediate overflow.

A combinational writeback path turns the accumulator into a single DW-bit word aligned to the operand format. It first rounds away the DW-1 low fraction bits using one of three modes: truncate, round-half-up, or round-half-to-even. It then applies an optional arithmetic left shift. Finally the result is either clamped to the word range or wrapped modulo 2^DW, as chosen by an input. When a writeback strobe meets a clamped value, a sticky overflow flag is set, and it stays set until it is cleared.

Top module: `fxp_mac`

## Requirements
- R1: While reset (rst_n low) is asserted and after it is released, the accumulator reads 0 and the overflow flag reads 0.
- R2: With op_valid high and op_sel = 2 (load), the accumulator holds the sign-extended full 2*DW-bit signed product a*b after the next rising edge, and its previous value is discarded.
- R3: op_sel = 0 adds the product to the accumulator and op_sel = 1 subtracts it. The accumulator is 2*DW+GUARD bits wide, so at least 2^GUARD products of the largest magnitude sum without wraparound.
- R4: op_sel = 3 clears the accumulator to 0. While op_valid is low the accumulator keeps its value whatever op_sel, a and b are.
- R5: With rnd_mode = 0 (truncate), and also for the unused code 3, the writeback value before shift is floor(acc / 2^(DW-1)): the low DW-1 bits are dropped.
- R6: With rnd_mode = 1 (round to nearest), the writeback value is floor(acc / 2^(DW-1)) plus 1 when the dropped remainder is half an LSB or more.
- R7: With rnd_mode = 2 (convergent), the value is incremented when the remainder is above half an LSB. At exactly half it is incremented only if the kept LSB is 1, so the result always has LSB 0.
- R8: The rounded value is multiplied by 2^shl_amt (arithmetic left shift) before the range check.
- R9: With sat_en high, a shifted value above 2^(DW-1)-1 gives 2^(DW-1)-1 and one below -2^(DW-1) gives -2^(DW-1). With sat_en low, wb_data is the low DW bits of the value.
- R10: ovf_flag rises on the edge after a cycle in which wb_rd is high, sat_en is high and the value is out of range. It then stays high until a cycle with ovf_clr high. If a set and a clear arrive in the same cycle, the set wins.
- R11: One operation is accepted every clock cycle. Back-to-back operations each take effect on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Apply op_sel this cycle |
| op_sel | input | 2 | 0 add, 1 subtract, 2 load, 3 clear |
| a_i | input | DW | Signed Q1.(DW-1) operand |
| b_i | input | DW | Signed Q1.(DW-1) operand |
| rnd_mode | input | 2 | 0 truncate, 1 nearest, 2 convergent, 3 truncate |
| sat_en | input | 1 | 1 clamps writeback, 0 wraps |
| shl_amt | input | SHW | Left shift applied on writeback |
| wb_rd | input | 1 | Writeback strobe that may set the overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| acc_out | output | 2*DW+GUARD | Signed accumulator contents |
| wb_data | output | DW | Rounded, shifted, clamped or wrapped writeback word |
| ovf_flag | output | 1 | Sticky writeback-clamp indicator |

## Verification
The accumulator is exposed directly, so a wrong product, a wrong sign on subtract, or a lost guard bit shows on acc_out one cycle after the operation. A fault in the rounding or clamping logic shows immediately on wb_data, because that path has no register. The bench therefore sweeps every operand pair of a 4-bit configuration and checks each accumulator value under every rounding mode, shift and saturation setting. A flag that fails to stick or clears wrongly shows one cycle after the offending strobe.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
   typedef enum logic [1:0] {
      MAC_ADD   = 2'd0,
      MAC_SUB   = 2'd1,
      MAC_LOAD  = 2'd2,
      MAC_CLEAR = 2'd3
   } mac_op_e;

   typedef enum logic [1:0] {
      RND_TRUNC = 2'd0,
      RND_NEAR  = 2'd1,
      RND_CONV  = 2'd2,
      RND_RSVD  = 2'd3
   } rnd_mode_e;
endpackage

// File: rtl/fxp_mac_mult.sv
module fxp_mac_mult #(
   parameter int DW = 16
) (
   input  logic signed [DW-1:0]   a_i,
   input  logic signed [DW-1:0]   b_i,
   output logic signed [2*DW-1:0] prod_o
);
   // full-width signed product, no truncation
   assign prod_o = a_i * b_i;
endmodule

// File: rtl/fxp_mac_accum.sv
module fxp_mac_accum
   import fxp_mac_pkg::*;
#(
   parameter int DW   = 16,
   parameter int ACCW = 40
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_i,
   input  logic [1:0]             op_i,
   input  logic [2*DW-1:0]        prod_i,
   output logic [ACCW-1:0]        acc_o
);
   localparam int PW = 2 * DW;
   localparam int XW = ACCW - PW;

   logic [ACCW-1:0] prod_ext;
   logic [ACCW-1:0] acc_nxt;

   assign prod_ext = {{XW{prod_i[PW-1]}}, prod_i};

   always_comb begin
      unique case (mac_op_e'(op_i))
         MAC_ADD:   acc_nxt = acc_o + prod_ext;
         MAC_SUB:   acc_nxt = acc_o - prod_ext;
         MAC_LOAD:  acc_nxt = prod_ext;
         default:   acc_nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_o <= '0;
      else if (en_i)  acc_o <= acc_nxt;
   end
endmodule

// File: rtl/fxp_mac_round.sv
module fxp_mac_round
   import fxp_mac_pkg::*;
#(
   parameter int DW   = 16,
   parameter int ACCW = 40,
   localparam int FB  = DW - 1,
   localparam int KW  = ACCW - FB,
   localparam int RW  = KW + 1
) (
   input  logic [ACCW-1:0] acc_i,
   input  logic [1:0]      mode_i,
   output logic [RW-1:0]   rnd_o
);
   logic [KW-1:0] kept;
   logic [FB-1:0] rem;
   logic [FB-1:0] half;
   logic          above, exact, bump;

   assign kept  = acc_i[ACCW-1:FB];
   assign rem   = acc_i[FB-1:0];
   assign half  = {1'b1, {(FB-1){1'b0}}};
   assign above = rem > half;
   assign exact = rem == half;

   always_comb begin
      unique case (rnd_mode_e'(mode_i))
         RND_NEAR: bump = above | exact;
         RND_CONV: bump = above | (exact & kept[0]);
         default:  bump = 1'b0;
      endcase
   end

   // one extra bit so the increment cannot wrap
   assign rnd_o = {kept[KW-1], kept} + {{(RW-1){1'b0}}, bump};
endmodule

// File: rtl/fxp_mac_clamp.sv
module fxp_mac_clamp #(
   parameter int DW       = 16,
   parameter int RW       = 26,
   parameter int SHW      = 2,
   parameter bit SHIFT_EN = 1'b1
) (
   input  logic [RW-1:0]  rnd_i,
   input  logic [SHW-1:0] shl_i,
   input  logic           sat_en_i,
   output logic [DW-1:0]  wb_o,
   output logic           clamp_o
);
   localparam int MAXS = (1 << SHW) - 1;
   localparam int XW   = RW + MAXS;
   localparam int HW   = XW - DW + 1;

   logic [XW-1:0] ext;
   logic [XW-1:0] shifted;
   logic [HW-1:0] hi;
   logic          fits;
   logic [DW-1:0] pos_lim, neg_lim;

   assign ext = {{MAXS{rnd_i[RW-1]}}, rnd_i};

   generate
      if (SHIFT_EN) begin : g_shift
         assign shifted = ext << shl_i;
      end else begin : g_noshift
         logic unused_shl;
         assign unused_shl = ^shl_i;
         assign shifted    = ext;
      end
   endgenerate

   // value fits in DW bits when every bit from the sign position up agrees
   assign hi      = shifted[XW-1:DW-1];
   assign fits    = (&hi) | ~(|hi);
   assign pos_lim = {1'b0, {(DW-1){1'b1}}};
   assign neg_lim = {1'b1, {(DW-1){1'b0}}};
   assign clamp_o = sat_en_i & ~fits;
   assign wb_o    = clamp_o ? (shifted[XW-1] ? neg_lim : pos_lim)
                            : shifted[DW-1:0];
endmodule

// File: rtl/fxp_mac.sv
module fxp_mac #(
   parameter int DW       = 16,
   parameter int GUARD    = 8,
   parameter int SHW      = 2,
   parameter bit SHIFT_EN = 1'b1,
   localparam int ACCW    = 2 * DW + GUARD,
   localparam int RW      = ACCW - DW + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [1:0]      op_sel,
   input  logic [DW-1:0]   a_i,
   input  logic [DW-1:0]   b_i,
   input  logic [1:0]      rnd_mode,
   input  logic            sat_en,
   input  logic [SHW-1:0]  shl_amt,
   input  logic            wb_rd,
   input  logic            ovf_clr,
   output logic [ACCW-1:0] acc_out,
   output logic [DW-1:0]   wb_data,
   output logic            ovf_flag
);
   generate
      if (DW < 3)    begin : g_bad_dw    $error("fxp_mac: DW must be at least 3"); end
      if (GUARD < 1) begin : g_bad_guard $error("fxp_mac: GUARD must be at least 1"); end
      if (SHW < 1)   begin : g_bad_shw   $error("fxp_mac: SHW must be at least 1"); end
   endgenerate

   logic [2*DW-1:0] prod;
   logic [RW-1:0]   rnd;
   logic            clamp;

   fxp_mac_mult #(.DW(DW)) u_mult (
      .a_i    (a_i),
      .b_i    (b_i),
      .prod_o (prod)
   );

   fxp_mac_accum #(.DW(DW), .ACCW(ACCW)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (op_valid),
      .op_i   (op_sel),
      .prod_i (prod),
      .acc_o  (acc_out)
   );

   fxp_mac_round #(.DW(DW), .ACCW(ACCW)) u_round (
      .acc_i  (acc_out),
      .mode_i (rnd_mode),
      .rnd_o  (rnd)
   );

   fxp_mac_clamp #(.DW(DW), .RW(RW), .SHW(SHW), .SHIFT_EN(SHIFT_EN)) u_clamp (
      .rnd_i    (rnd),
      .shl_i    (shl_amt),
      .sat_en_i (sat_en),
      .wb_o     (wb_data),
      .clamp_o  (clamp)
   );

   // sticky flag, a new clamp event takes priority over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovf_flag <= 1'b0;
      else if (wb_rd && clamp)   ovf_flag <= 1'b1;
      else if (ovf_clr)          ovf_flag <= 1'b0;
   end
endmodule

// File: rtl/fxp_mac_chk.sv
module fxp_mac_chk #(
   parameter int DW    = 16,
   parameter int GUARD = 8,
   parameter int SHW   = 2,
   localparam int ACCW = 2 * DW + GUARD
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [1:0]      op_sel,
   input logic [DW-1:0]   a_i,
   input logic [DW-1:0]   b_i,
   input logic            sat_en,
   input logic            wb_rd,
   input logic            ovf_clr,
   input logic [ACCW-1:0] acc_out,
   input logic [DW-1:0]   wb_data,
   input logic            ovf_flag
);
   logic signed [2*DW-1:0] prod_c;
   logic signed [ACCW-1:0] prod_x;
   logic [DW-1:0]          max_w, min_w;

   assign prod_c = $signed(a_i) * $signed(b_i);
   assign prod_x = prod_c;
   assign max_w  = {1'b0, {(DW-1){1'b1}}};
   assign min_w  = {1'b1, {(DW-1){1'b0}}};

   always_comb begin
      if (!rst_n) begin
         assert_reset_state_R1: assert (acc_out == '0 && ovf_flag == 1'b0);
      end
   end

   assert_load_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 2'd2) |=> ($signed(acc_out) == $past(prod_x)));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 2'd3) |=> (acc_out == '0));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(acc_out));

   assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(wb_rd) && $past(sat_en) &&
                           ($past(wb_data) == max_w || $past(wb_data) == min_w)));

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !wb_rd) |=> !ovf_flag);
endmodule

bind fxp_mac fxp_mac_chk #(.DW(DW), .GUARD(GUARD), .SHW(SHW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_sel   (op_sel),
   .a_i      (a_i),
   .b_i      (b_i),
   .sat_en   (sat_en),
   .wb_rd    (wb_rd),
   .ovf_clr  (ovf_clr),
   .acc_out  (acc_out),
   .wb_data  (wb_data),
   .ovf_flag (ovf_flag)
);

// File: tb/sim_fxp_mac.sv
`timescale 1ns/100ps
module sim_fxp_mac;
   localparam int DW    = 4;
   localparam int GUARD = 3;
   localparam int SHW   = 2;
   localparam int ACCW  = 2 * DW + GUARD;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [1:0]      op_sel = 2'd0;
   logic [DW-1:0]   a_i = '0;
   logic [DW-1:0]   b_i = '0;
   logic [1:0]      rnd_mode = 2'd0;
   logic            sat_en = 1'b0;
   logic [SHW-1:0]  shl_amt = '0;
   logic            wb_rd = 1'b0;
   logic            ovf_clr = 1'b0;
   logic [ACCW-1:0] acc_out;
   logic [DW-1:0]   wb_data;
   logic            ovf_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fxp_mac #(.DW(DW), .GUARD(GUARD), .SHW(SHW)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .a_i(a_i), .b_i(b_i), .rnd_mode(rnd_mode), .sat_en(sat_en),
      .shl_amt(shl_amt), .wb_rd(wb_rd), .ovf_clr(ovf_clr),
      .acc_out(acc_out), .wb_data(wb_data), .ovf_flag(ovf_flag)
   );

   task automatic chk(input int got, input int exp, input string tag);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int acc_v();
      return int'($signed(acc_out));
   endfunction

   function automatic int wb_v();
      return int'($signed(wb_data));
   endfunction

   // arithmetic model of the writeback path for DW = 4 (3 fraction bits dropped)
   function automatic int model_wb(input int acc, input int mode, input int sat, input int sh);
      int k;
      int r;
      int s;
      k = acc >>> 3;
      r = acc & 7;
      if (mode == 1 && r >= 4) k = k + 1;
      if (mode == 2 && (r > 4 || (r == 4 && (k & 1) == 1))) k = k + 1;
      s = k * (1 << sh);
      if (sat != 0) begin
         if (s > 7)  s = 7;
         if (s < -8) s = -8;
      end else begin
         s = s & 15;
         if (s > 7) s = s - 16;
      end
      return s;
   endfunction

   task automatic do_op(input int op, input int a, input int b);
      @(negedge clk);
      op_valid = 1'b1;
      op_sel   = 2'(op);
      a_i      = 4'(a);
      b_i      = 4'(b);
      @(posedge clk);
      #1;
      op_valid = 1'b0;
   endtask

   initial begin
      // R1: reset state
      #1;
      chk(acc_v(), 0, "R1 acc during reset");
      chk(int'(ovf_flag), 0, "R1 flag during reset");
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(acc_v(), 0, "R1 acc after reset");
      chk(int'(ovf_flag), 0, "R1 flag after reset");

      // R2 and R5-R9: every operand pair, every writeback setting
      for (int a = -8; a < 8; a++) begin
         for (int b = -8; b < 8; b++) begin
            do_op(2, a, b);
            chk(acc_v(), a * b, "R2 load product");
            for (int m = 0; m < 4; m++) begin
               for (int s = 0; s < 2; s++) begin
                  for (int sh = 0; sh < 4; sh++) begin
                     rnd_mode = 2'(m);
                     sat_en   = 1'(s);
                     shl_amt  = 2'(sh);
                     #1;
                     if (m == 1)      chk(wb_v(), model_wb(a * b, m, s, sh), "R6 R8 R9 nearest");
                     else if (m == 2) chk(wb_v(), model_wb(a * b, m, s, sh), "R7 R8 R9 convergent");
                     else             chk(wb_v(), model_wb(a * b, m, s, sh), "R5 R8 R9 truncate");
                  end
               end
            end
         end
      end

      // R7 tie cases at exactly half an LSB: 12 (kept 1 -> 2), 20 (kept 2 -> 2), -4 (kept -1 -> 0)
      rnd_mode = 2'd2; sat_en = 1'b1; shl_amt = '0;
      do_op(2, 3, 4);
      chk(wb_v(), 2, "R7 tie odd rounds up");
      do_op(2, 5, 4);
      chk(wb_v(), 2, "R7 tie even stays");
      do_op(2, -1, 4);
      chk(wb_v(), 0, "R7 negative tie to even");
      rnd_mode = 2'd1;
      #1;
      chk(wb_v(), 0, "R6 negative half rounds up");

      // R3 and R11: back-to-back accumulation of the largest product
      do_op(2, -8, -8);
      chk(acc_v(), 64, "R3 first load");
      @(negedge clk);
      op_valid = 1'b1; op_sel = 2'd0; a_i = 4'(-8); b_i = 4'(-8);
      for (int i = 2; i <= 15; i++) begin
         @(posedge clk);
         #1;
         chk(acc_v(), 64 * i, "R3 R11 consecutive add");
      end
      op_valid = 1'b0;
      do_op(1, 7, 7);
      chk(acc_v(), 960 - 49, "R3 subtract");

      // R4: hold with op_valid low despite active inputs
      @(negedge clk);
      op_sel = 2'd3; a_i = 4'(5); b_i = 4'(5);
      repeat (3) @(posedge clk);
      #1;
      chk(acc_v(), 911, "R4 hold while not valid");

      // R9 and R10: overflow flag behaviour
      rnd_mode = 2'd0; sat_en = 1'b1; shl_amt = '0;
      #1;
      chk(wb_v(), 7, "R9 large positive clamps");
      chk(int'(ovf_flag), 0, "R10 no flag without strobe");
      @(negedge clk); wb_rd = 1'b1;
      @(posedge clk); #1;
      chk(int'(ovf_flag), 1, "R10 flag set on clamp");
      @(negedge clk); sat_en = 1'b0;
      repeat (2) @(posedge clk); #1;
      chk(int'(ovf_flag), 1, "R10 flag sticky");
      @(negedge clk); wb_rd = 1'b0; ovf_clr = 1'b1;
      @(posedge clk); #1;
      chk(int'(ovf_flag), 0, "R10 flag cleared");
      @(negedge clk); ovf_clr = 1'b0; wb_rd = 1'b1;
      @(posedge clk); #1;
      chk(int'(ovf_flag), 0, "R10 wrap mode never sets flag");
      @(negedge clk); sat_en = 1'b1; ovf_clr = 1'b1;
      @(posedge clk); #1;
      chk(int'(ovf_flag), 1, "R10 set wins over clear");
      @(negedge clk); wb_rd = 1'b0; ovf_clr = 1'b1;
      @(posedge clk); #1;
      ovf_clr = 1'b0;
      chk(int'(ovf_flag), 0, "R10 clear after event");

      // R3 negative direction and R9 negative clamp
      do_op(2, 7, -8);
      do_op(0, 7, -8);
      chk(acc_v(), -112, "R3 negative accumulation");
      #1;
      chk(wb_v(), -8, "R9 large negative clamps");
      sat_en = 1'b0;
      #1;
      chk(wb_v(), 2, "R9 wrap keeps low bits");

      // R4: clear
      do_op(3, 1, 1);
      chk(acc_v(), 0, "R4 clear");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule